// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a small array of interrupt sources and decides when each one is offered to a presentation layer. Each source is either edge-style (message) or level-style, chosen by a per-source type bit. For every source the block stores a target server, a current priority, a saved priority, and four status flags: asserted, sent, rejected and masked-pending. A priority of 0xFF means the source is masked.

Sources are addressed by a global number, which is the local index plus the `BASE` parameter. A configuration port carries four commands. Set, query, disable and enable each take effect in the cycle they are accepted, and a response is returned one cycle later. The presentation layer can hand back a reject or an end-of-interrupt for a global number. A resend request walks every source once, one source per cycle, and re-offers what was rejected or is still owed.

Presentations leave through one registered output with a valid/ready handshake, one request at a time. When several sources are owed at once, the lowest local index goes first.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no presentation is offered, every server is 0, and every current and saved priority is 0xFF; a query of any source returns server 0 and priority 0xFF.
- R2: A source's global number is its index plus `BASE`. A command whose number lies outside `BASE` to `BASE+NUM_SRC-1` returns `cfg_err_o`=1 and changes nothing. Rejects and end-of-interrupts with such a number are ignored.
- R3: A rising line on an unmasked message source produces one presentation carrying that source's server, its global number and its priority.
- R4: A rising line on a masked message source is not presented; it sets masked-pending. A later set or enable that leaves the source unmasked clears the flag and presents the source once. No presentation ever carries priority 0xFF.
- R5: A level source tracks its line in the asserted flag. On a rising line, the source is presented only if it is unmasked and not already sent, and presenting it sets the sent flag. A resend does not repeat it while sent is set.
- R6: A reject sets the source's rejected flag and clears its sent flag. A rejected, unmasked message source is presented again by the next resend scan, and only once.
- R7: An end-of-interrupt clears the sent flag of a level source only. A level source still asserted is then presented again by a resend. An end-of-interrupt to a message source has no visible effect.
- R8: Disable (cmd 2'b10) stores the current priority as the saved priority and sets the priority to 0xFF. Enable (cmd 2'b11) copies the saved priority back into the priority and then presents the source if it is owed.
- R9: Set (cmd 2'b00) writes the server and sets both priorities to the given value. Query (cmd 2'b01) returns the server and current priority on `cfg_server_o`/`cfg_prio_o`, with `cfg_done_o` high one cycle after the command.
- R10: While `pres_valid_o` is high and `pres_ready_i` is low, the presentation fields stay unchanged. Owed sources are offered lowest index first.
- R11: A resend scan visits one source per clock and holds its position while a presentation waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_is_level_i | input | NUM_SRC | Per-source type: 1 level, 0 message |
| src_line_i | input | NUM_SRC | Per-source interrupt lines, synchronous to clk |
| cfg_valid_i | input | 1 | Configuration command strobe |
| cfg_cmd_i | input | 2 | 00 set, 01 query, 10 disable, 11 enable |
| cfg_num_i | input | NUM_W | Global source number of the command |
| cfg_server_i | input | SRV_W | Server for set |
| cfg_prio_i | input | 8 | Priority for set |
| cfg_done_o | output | 1 | Command response valid, one cycle after the command |
| cfg_err_o | output | 1 | Number out of range |
| cfg_server_o | output | SRV_W | Query result: server |
| cfg_prio_o | output | 8 | Query result: current priority |
| rej_valid_i | input | 1 | Reject strobe from presentation layer |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number being completed |
| resend_i | input | 1 | Start a resend scan |
| pres_valid_o | output | 1 | Presentation request valid |
| pres_ready_i | input | 1 | Presentation layer accepts the request |
| pres_server_o | output | SRV_W | Target server |
| pres_num_o | output | NUM_W | Global source number |
| pres_prio_o | output | 8 | Priority |

## Verification
The hardest situation to reach from the ports is a source that is owed again only because of an earlier reject or end-of-interrupt. The stimulus has to take the source through present, hand-back and resend, while the line state at each step decides the expected outcome. The bench drives a level source through raise, present, resend-with-sent-still-set, end-of-interrupt, resend, then lowers the line and repeats. It also rejects two message sources and checks that one scan offers both, lowest index first, while ready is held low.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

    typedef enum logic [1:0] {
        CMD_SET   = 2'b00,
        CMD_QUERY = 2'b01,
        CMD_OFF   = 2'b10,
        CMD_ON    = 2'b11
    } cfg_cmd_e;

endpackage

// File: rtl/irq_src_edge.sv
// Per-source rising-edge detector on synchronous interrupt lines.
module irq_src_edge #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [NUM_SRC-1:0] prev_d, prev_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        always_comb begin
            prev_d[g] = line_i[g];
            rise_o[g] = line_i[g] & ~prev_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= prev_d[g];
        end
    end
endmodule

// File: rtl/irq_src_range.sv
// Maps a global source number to a local index and flags whether it is valid.
module irq_src_range #(
    parameter int NUM_SRC = 16,
    parameter int NUM_W   = 16,
    parameter int BASE    = 4096,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_W-1:0] num_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    int unsigned off;

    always_comb begin
        off   = 32'(num_i) - 32'(BASE);
        hit_o = (32'(num_i) >= 32'(BASE)) && (off < 32'(NUM_SRC));
        idx_o = hit_o ? IDX_W'(off) : '0;
    end
endmodule

// File: rtl/irq_src_pick.sv
// Lowest-index selection among owed sources.
module irq_src_pick #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int SRV_W   = 4,
    parameter int NUM_W   = 16,
    parameter int BASE    = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_is_level_i,
    input  logic [NUM_SRC-1:0]   src_line_i,
    input  logic                 cfg_valid_i,
    input  logic [1:0]           cfg_cmd_i,
    input  logic [NUM_W-1:0]     cfg_num_i,
    input  logic [SRV_W-1:0]     cfg_server_i,
    input  logic [PRIO_W-1:0]    cfg_prio_i,
    output logic                 cfg_done_o,
    output logic                 cfg_err_o,
    output logic [SRV_W-1:0]     cfg_server_o,
    output logic [PRIO_W-1:0]    cfg_prio_o,
    input  logic                 rej_valid_i,
    input  logic [NUM_W-1:0]     rej_num_i,
    input  logic                 eoi_valid_i,
    input  logic [NUM_W-1:0]     eoi_num_i,
    input  logic                 resend_i,
    output logic                 pres_valid_o,
    input  logic                 pres_ready_i,
    output logic [SRV_W-1:0]     pres_server_o,
    output logic [NUM_W-1:0]     pres_num_o,
    output logic [PRIO_W-1:0]    pres_prio_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    typedef struct packed {
        logic [SRV_W-1:0]  srv;
        logic [PRIO_W-1:0] prio;
        logic [PRIO_W-1:0] saved;
        logic              asserted;
        logic              sent;
        logic              rejected;
        logic              mpend;
        logic              owed;     // presentation queued, not yet on the output
    } src_rec_t;

    typedef struct packed {
        src_rec_t [NUM_SRC-1:0] src;
        logic                   scan_on;
        logic [IDX_W-1:0]       scan_idx;
        logic                   pv;
        logic [SRV_W-1:0]       psrv;
        logic [NUM_W-1:0]       pnum;
        logic [PRIO_W-1:0]      pprio;
        logic                   cdone;
        logic                   cerr;
        logic [SRV_W-1:0]       csrv;
        logic [PRIO_W-1:0]      cprio;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            s.src[i].prio  = PRIO_MASKED;
            s.src[i].saved = PRIO_MASKED;
        end
        return s;
    endfunction

    // Level rule: offer when unmasked, asserted and not yet sent.
    function automatic src_rec_t level_check(src_rec_t r);
        src_rec_t o;
        o = r;
        if (r.prio != PRIO_MASKED && r.asserted && !r.sent) begin
            o.sent = 1'b1;
            o.owed = 1'b1;
        end
        return o;
    endfunction

    // Follow-up after a priority write.
    function automatic src_rec_t after_write(src_rec_t r, logic lvl);
        src_rec_t o;
        o = r;
        if (lvl) begin
            o = level_check(r);
        end else if (r.mpend && r.prio != PRIO_MASKED) begin
            o.mpend = 1'b0;
            o.owed  = 1'b1;
        end
        return o;
    endfunction

    state_t             st_d, st_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] owed_vec;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               cfg_hit, rej_hit, eoi_hit;
    logic [IDX_W-1:0]   cfg_idx, rej_idx, eoi_idx;
    logic               out_free;
    logic               out_stall;
    cfg_cmd_e           cmd;

    irq_src_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (src_line_i),
        .rise_o (rise)
    );

    irq_src_range #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .IDX_W(IDX_W)) u_cfg_rng (
        .num_i (cfg_num_i), .hit_o (cfg_hit), .idx_o (cfg_idx)
    );
    irq_src_range #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .IDX_W(IDX_W)) u_rej_rng (
        .num_i (rej_num_i), .hit_o (rej_hit), .idx_o (rej_idx)
    );
    irq_src_range #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .IDX_W(IDX_W)) u_eoi_rng (
        .num_i (eoi_num_i), .hit_o (eoi_hit), .idx_o (eoi_idx)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_owed
        assign owed_vec[g] = st_q.src[g].owed;
    end

    irq_src_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req_i (owed_vec),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    assign out_free  = !st_q.pv || pres_ready_i;
    assign out_stall = st_q.pv && !pres_ready_i;
    assign cmd       = cfg_cmd_e'(cfg_cmd_i);

    always_comb begin
        st_d       = st_q;
        st_d.cdone = 1'b0;
        st_d.cerr  = 1'b0;
        st_d.csrv  = '0;
        st_d.cprio = '0;

        // Output register: retire on ready, then load the lowest owed source.
        if (st_q.pv && pres_ready_i) st_d.pv = 1'b0;
        if (out_free && pick_any) begin
            st_d.src[pick_idx].owed = 1'b0;
            if (st_q.src[pick_idx].prio == PRIO_MASKED) begin
                // Masked after being queued: keep it owed in flag form.
                if (src_is_level_i[pick_idx]) st_d.src[pick_idx].sent  = 1'b0;
                else                          st_d.src[pick_idx].mpend = 1'b1;
            end else begin
                st_d.pv    = 1'b1;
                st_d.psrv  = st_q.src[pick_idx].srv;
                st_d.pnum  = NUM_W'(BASE + int'(pick_idx));
                st_d.pprio = st_q.src[pick_idx].prio;
            end
        end

        // Interrupt lines.
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_is_level_i[i]) begin
                st_d.src[i].asserted = src_line_i[i];
                if (rise[i]) st_d.src[i] = level_check(st_d.src[i]);
            end else if (rise[i]) begin
                if (st_d.src[i].prio == PRIO_MASKED) st_d.src[i].mpend = 1'b1;
                else                                 st_d.src[i].owed  = 1'b1;
            end
        end

        // Hand-backs from the presentation layer.
        if (rej_valid_i && rej_hit) begin
            st_d.src[rej_idx].rejected = 1'b1;
            st_d.src[rej_idx].sent     = 1'b0;
        end
        if (eoi_valid_i && eoi_hit && src_is_level_i[eoi_idx]) begin
            st_d.src[eoi_idx].sent = 1'b0;
        end

        // Configuration commands.
        if (cfg_valid_i) begin
            st_d.cdone = 1'b1;
            if (!cfg_hit) begin
                st_d.cerr = 1'b1;
            end else begin
                unique case (cmd)
                    CMD_SET: begin
                        st_d.src[cfg_idx].srv   = cfg_server_i;
                        st_d.src[cfg_idx].prio  = cfg_prio_i;
                        st_d.src[cfg_idx].saved = cfg_prio_i;
                        st_d.src[cfg_idx] = after_write(st_d.src[cfg_idx], src_is_level_i[cfg_idx]);
                    end
                    CMD_QUERY: begin
                        st_d.csrv  = st_d.src[cfg_idx].srv;
                        st_d.cprio = st_d.src[cfg_idx].prio;
                    end
                    CMD_OFF: begin
                        st_d.src[cfg_idx].saved = st_d.src[cfg_idx].prio;
                        st_d.src[cfg_idx].prio  = PRIO_MASKED;
                        st_d.src[cfg_idx] = after_write(st_d.src[cfg_idx], src_is_level_i[cfg_idx]);
                    end
                    CMD_ON: begin
                        st_d.src[cfg_idx].prio = st_d.src[cfg_idx].saved;
                        st_d.src[cfg_idx] = after_write(st_d.src[cfg_idx], src_is_level_i[cfg_idx]);
                    end
                    default: ;
                endcase
            end
        end

        // Resend scan: one source per cycle, held while the output is stalled.
        if (st_q.scan_on) begin
            if (!out_stall) begin
                if (src_is_level_i[st_q.scan_idx]) begin
                    st_d.src[st_q.scan_idx] = level_check(st_d.src[st_q.scan_idx]);
                end else if (st_d.src[st_q.scan_idx].rejected) begin
                    st_d.src[st_q.scan_idx].rejected = 1'b0;
                    if (st_d.src[st_q.scan_idx].prio != PRIO_MASKED)
                        st_d.src[st_q.scan_idx].owed = 1'b1;
                end
                if (st_q.scan_idx == LAST_IDX) st_d.scan_on = 1'b0;
                else                           st_d.scan_idx = st_q.scan_idx + 1'b1;
            end
        end else if (resend_i) begin
            st_d.scan_on  = 1'b1;
            st_d.scan_idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign pres_valid_o  = st_q.pv;
    assign pres_server_o = st_q.psrv;
    assign pres_num_o    = st_q.pnum;
    assign pres_prio_o   = st_q.pprio;
    assign cfg_done_o    = st_q.cdone;
    assign cfg_err_o     = st_q.cerr;
    assign cfg_server_o  = st_q.csrv;
    assign cfg_prio_o    = st_q.cprio;

    AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid_o && !pres_ready_i |=> pres_valid_o && $stable(pres_num_o)
            && $stable(pres_prio_o) && $stable(pres_server_o)); // R10

    AST_PRES_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid_o |-> pres_prio_o != PRIO_MASKED); // R4

    AST_PRES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid_o |-> (32'(pres_num_o) >= 32'(BASE))
            && (32'(pres_num_o) < 32'(BASE + NUM_SRC))); // R2

    AST_CFG_BAD_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_i && !cfg_hit |=> cfg_done_o && cfg_err_o); // R2

    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.scan_on && pres_valid_o && !pres_ready_i |=> $stable(st_q.scan_idx)); // R11

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.scan_on && !(pres_valid_o && !pres_ready_i) && st_q.scan_idx != LAST_IDX
            |=> st_q.scan_idx == $past(st_q.scan_idx) + 1'b1); // R11

endmodule

// File: tb/irq_src_ctrl_tb_top.sv
module irq_src_ctrl_tb_top;
    localparam int N     = 16;
    localparam int SRV_W = 4;
    localparam int NUM_W = 16;
    localparam int BASE  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     is_level = 16'hFF00;   // 8..15 level, 0..7 message
    logic [N-1:0]     line = '0;
    logic             cfg_valid = 1'b0;
    logic [1:0]       cfg_cmd = 2'b00;
    logic [NUM_W-1:0] cfg_num = '0;
    logic [SRV_W-1:0] cfg_srv = '0;
    logic [7:0]       cfg_prio = '0;
    logic             cfg_done, cfg_err;
    logic [SRV_W-1:0] cfg_srv_o;
    logic [7:0]       cfg_prio_o;
    logic             rej_valid = 1'b0;
    logic [NUM_W-1:0] rej_num = '0;
    logic             eoi_valid = 1'b0;
    logic [NUM_W-1:0] eoi_num = '0;
    logic             resend = 1'b0;
    logic             pv;
    logic             pready = 1'b0;
    logic [SRV_W-1:0] psrv;
    logic [NUM_W-1:0] pnum;
    logic [7:0]       pprio;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_src_ctrl #(.NUM_SRC(N), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_is_level_i(is_level), .src_line_i(line),
        .cfg_valid_i(cfg_valid), .cfg_cmd_i(cfg_cmd), .cfg_num_i(cfg_num),
        .cfg_server_i(cfg_srv), .cfg_prio_i(cfg_prio),
        .cfg_done_o(cfg_done), .cfg_err_o(cfg_err),
        .cfg_server_o(cfg_srv_o), .cfg_prio_o(cfg_prio_o),
        .rej_valid_i(rej_valid), .rej_num_i(rej_num),
        .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num),
        .resend_i(resend),
        .pres_valid_o(pv), .pres_ready_i(pready),
        .pres_server_o(psrv), .pres_num_o(pnum), .pres_prio_o(pprio)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [1:0] c, input int num, input int srv, input int pr,
                          output int err, output int rsrv, output int rprio);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_cmd = c; cfg_num = NUM_W'(num);
        cfg_srv = SRV_W'(srv); cfg_prio = 8'(pr);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (!cfg_done) begin
            checks++; failures++;
            $display("FAIL R9 cfg_done: actual=0 expected=1");
        end
        err = int'(cfg_err); rsrv = int'(cfg_srv_o); rprio = int'(cfg_prio_o);
    endtask

    task automatic set_src(int num, int srv, int pr);
        int e, s, p;
        do_cfg(2'b00, num, srv, pr, e, s, p);
        check("R9", "set err", e, 0);
    endtask

    task automatic expect_pres(string req, int srv, int num, int pr, int hold);
        bit seen = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            if (pv) seen = 1;
        end
        check(req, "pres seen", int'(seen), 1);
        if (seen) begin
            check(req, "pres num", int'(pnum), num);
            check(req, "pres server", int'(psrv), srv);
            check(req, "pres prio", int'(pprio), pr);
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                check("R10", "held num", int'(pnum), num);
                check("R10", "held valid", int'(pv), 1);
            end
            pready = 1'b1;
            @(negedge clk);
            pready = 1'b0;
        end
    endtask

    task automatic expect_none(string req, int cycles);
        bit seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pv) seen = 1;
        end
        check(req, "no presentation", int'(seen), 0);
        if (seen) begin
            pready = 1'b1; @(negedge clk); pready = 1'b0;
        end
    endtask

    task automatic pulse_line(int i);
        @(negedge clk); line[i] = 1'b1;
        @(negedge clk); line[i] = 1'b0;
    endtask

    task automatic do_reject(int num);
        @(negedge clk); rej_valid = 1'b1; rej_num = NUM_W'(num);
        @(negedge clk); rej_valid = 1'b0;
    endtask

    task automatic do_eoi(int num);
        @(negedge clk); eoi_valid = 1'b1; eoi_num = NUM_W'(num);
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic do_resend();
        @(negedge clk); resend = 1'b1;
        @(negedge clk); resend = 1'b0;
    endtask

    task automatic t_reset();
        int e, s, p;
        check("R1", "valid after reset", int'(pv), 0);
        do_cfg(2'b01, BASE + 6, 0, 0, e, s, p);
        check("R1", "query err", e, 0);
        check("R1", "server", s, 0);
        check("R1", "prio", p, 8'hFF);
    endtask

    task automatic t_range();
        int e, s, p;
        do_cfg(2'b01, BASE - 1, 0, 0, e, s, p);
        check("R2", "below base err", e, 1);
        do_cfg(2'b00, BASE + N, 3, 1, e, s, p);
        check("R2", "above top err", e, 1);
        do_cfg(2'b01, BASE + N - 1, 0, 0, e, s, p);
        check("R2", "top valid err", e, 0);
        check("R2", "top prio untouched", p, 8'hFF);
    endtask

    task automatic t_msg();
        set_src(BASE + 1, 3, 5);
        expect_none("R3", 6);
        pulse_line(1);
        expect_pres("R3", 3, BASE + 1, 5, 0);
        expect_none("R3", 6);
    endtask

    task automatic t_masked();
        pulse_line(2);
        expect_none("R4", 6);
        set_src(BASE + 2, 2, 7);
        expect_pres("R4", 2, BASE + 2, 7, 0);
        set_src(BASE + 2, 2, 6);
        expect_none("R4", 6);
    endtask

    task automatic t_level();
        set_src(BASE + 9, 1, 4);
        expect_none("R5", 4);
        @(negedge clk); line[9] = 1'b1;
        expect_pres("R5", 1, BASE + 9, 4, 0);
        do_resend();
        expect_none("R5", N + 6);
        do_eoi(BASE + 9);
        expect_none("R7", 4);
        do_resend();
        expect_pres("R7", 1, BASE + 9, 4, 0);
        @(negedge clk); line[9] = 1'b0;
        do_eoi(BASE + 9);
        do_resend();
        expect_none("R7", N + 6);
    endtask

    task automatic t_reject();
        pulse_line(1);
        expect_pres("R6", 3, BASE + 1, 5, 0);
        do_reject(BASE + 1);
        expect_none("R6", 4);
        do_resend();
        expect_pres("R6", 3, BASE + 1, 5, 0);
        do_resend();
        expect_none("R6", N + 6);
        do_eoi(BASE + 1);
        do_resend();
        expect_none("R7", N + 6);
        do_reject(BASE + N + 3);   // out of range, ignored
        do_resend();
        expect_none("R2", N + 6);
    endtask

    task automatic t_offon();
        int e, s, p;
        set_src(BASE + 3, 1, 8'h20);
        do_cfg(2'b10, BASE + 3, 0, 0, e, s, p);
        check("R8", "off err", e, 0);
        do_cfg(2'b01, BASE + 3, 0, 0, e, s, p);
        check("R8", "prio after off", p, 8'hFF);
        pulse_line(3);
        expect_none("R8", 6);
        do_cfg(2'b11, BASE + 3, 0, 0, e, s, p);
        expect_pres("R8", 1, BASE + 3, 8'h20, 0);
        do_cfg(2'b01, BASE + 3, 0, 0, e, s, p);
        check("R8", "prio after on", p, 8'h20);
    endtask

    task automatic t_query();
        int e, s, p;
        set_src(BASE + 4, 7, 8'h11);
        do_cfg(2'b01, BASE + 4, 0, 0, e, s, p);
        check("R9", "query server", s, 7);
        check("R9", "query prio", p, 8'h11);
    endtask

    task automatic t_order();
        @(negedge clk); line[3] = 1'b1; line[1] = 1'b1;
        @(negedge clk); line[3] = 1'b0; line[1] = 1'b0;
        expect_pres("R10", 3, BASE + 1, 5, 3);
        expect_pres("R10", 1, BASE + 3, 8'h20, 0);
    endtask

    task automatic t_scan();
        pulse_line(1);
        expect_pres("R11", 3, BASE + 1, 5, 0);
        do_reject(BASE + 1);
        pulse_line(3);
        expect_pres("R11", 1, BASE + 3, 8'h20, 0);
        do_reject(BASE + 3);
        do_resend();
        expect_pres("R11", 3, BASE + 1, 5, 4);
        expect_pres("R11", 1, BASE + 3, 8'h20, 0);
        expect_none("R11", N + 6);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_range();
        t_msg();
        t_masked();
        t_level();
        t_reject();
        t_offon();
        t_query();
        t_order();
        t_scan();
        finish_run();
    end
endmodule